// File: doc/BRIEF.md
# Serial-Load Shift Register with Output Holding Register

The block turns a bit-serial stream into a parallel word in two separate steps. A rising edge on the shift strobe pushes the serial data bit into the lowest stage of a shift chain, and every other stage moves up by one. A rising edge on the load strobe copies the whole chain into a holding register, and that register drives the parallel outputs. The serial output always shows the top stage of the chain. Several instances can be chained by feeding one serial output into the next serial input, with the strobes shared.

Both strobes and the serial data bit are slow level signals sampled on the system clock. They pass through a shared synchronizer of `SYNC_STAGES` flops, and a rising-edge detector turns each strobe into a one-cycle pulse. An active-low clear empties the shift chain at once, without waiting for a clock, and does not touch the holding register. An active-low output enable gates the parallel outputs. Outside the block, each parallel line becomes a tri-state pad, with `par_oe` as its drive enable. The serial output is never gated.

Top module: `shreg_latch`

## Requirements
- R1: A rising edge of `shift_lvl` moves `ser_in` into stage 0 (bit 0 of the word) and stage i into stage i+1. The old top stage is discarded.
- R2: A rising edge of `load_lvl` copies all `WIDTH` stages into the holding register in parallel. Stage i goes to holding bit i.
- R3: While `clr_n` is low, the shift chain reads all zeros and `ser_out` is low, with no clock edge needed. The holding register and the parallel outputs keep their values.
- R4: With `oe_n` low, `par_oe` is all ones and `par_q` equals the holding register. With `oe_n` high, `par_oe` is all zeros (all lines released) and `par_q` is all zeros.
- R5: `ser_out` equals the top shift stage at all times. Neither `oe_n` nor the load strobe affects it.
- R6: If `shift_lvl` shows no rising edge (including when it is held high for many cycles) and the clear is inactive, the shift chain keeps its contents. If `load_lvl` shows no rising edge, the holding register keeps its contents.
- R7: When both strobes rise in the same clock cycle, the holding register captures the chain contents from before that shift.
- R8: After `rst_n` is released, the holding register is all zeros. The shift chain is also zero, because `rst_n` clears it as well.
- R9: A strobe edge that is set up before a clock edge takes effect on the registers after exactly `SYNC_STAGES`+1 rising clock edges (3 with the default setting).
- R10: Chaining two instances (the first `ser_out` into the second `ser_in`, with shared strobes) gives a 2·`WIDTH`-bit shift chain. After 2·`WIDTH` shifts and one load, the first serial bit is at the top bit of the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low power-on initialization of all state |
| ser_in | input | 1 | Serial data bit |
| shift_lvl | input | 1 | Shift strobe level; acts on its rising edge |
| load_lvl | input | 1 | Load strobe level; acts on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain only |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_q | output | WIDTH | Parallel data from the holding register (zero when released) |
| par_oe | output | WIDTH | Per-line drive enable for the tri-state pads |
| ser_out | output | 1 | Top shift stage, always driven |

## Verification
The hardest case to reach is a shift and a load landing in the same sampled cycle. Without it, nothing shows whether the holding register takes the chain contents from before or after the shift. The bench raises both strobe levels at the same falling clock edge, so they cross the synchronizer together and give pulses in the same cycle. Random mixes of shift, load, simultaneous shift-and-load, clear pulses and enable toggles are driven on two chained instances. These cover the asynchronous clear with a non-zero holding register, and loads while the outputs are released.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int DEF_WIDTH = 8;
    localparam int DEF_SYNC  = 2;

    // Index of each sampled input inside the synchronizer bundle
    localparam int IDX_DATA  = 0;
    localparam int IDX_SHIFT = 1;
    localparam int IDX_LOAD  = 2;
    localparam int NUM_SAMPLED = 3;

    // One-cycle pulses produced by the edge detector
    typedef struct packed {
        logic shift;
        logic load;
    } pulse_t;

endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][N-1:0] pipe_d;
            logic [STAGES-1:0][N-1:0] pipe_q;

            always_comb begin
                pipe_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign q = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/shreg_edge.sv
module shreg_edge
    import shreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shift_s,
    input  logic   load_s,
    output pulse_t pulse
);

    typedef struct packed {
        logic shift_prev;
        logic load_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.shift_prev = shift_s;
        st_d.load_prev  = load_s;
        pulse.shift     = shift_s & ~st_q.shift_prev;
        pulse.load      = load_s  & ~st_q.load_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/shreg_chain.sv
module shreg_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_async_n,
    input  logic             step,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (step) begin
            ch_d.bits = {ch_q.bits[WIDTH-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge clr_async_n) begin
        if (!clr_async_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign stages = ch_q.bits;

endmodule

// File: rtl/shreg_hold.sv
module shreg_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] held
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (capture) begin
            hd_d.word = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign held = hd_q.word;

endmodule

// File: rtl/shreg_latch.sv
module shreg_latch
    import shreg_pkg::*;
#(
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_lvl,
    input  logic             load_lvl,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_q,
    output logic [WIDTH-1:0] par_oe,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    logic [NUM_SAMPLED-1:0] raw_in;
    logic [NUM_SAMPLED-1:0] smp;
    pulse_t                 pulse;
    logic                   shift_pulse;
    logic                   load_pulse;
    logic                   chain_rst_n;
    logic [WIDTH-1:0]       stages;
    logic [WIDTH-1:0]       held;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_DATA]  = ser_in;
        raw_in[IDX_SHIFT] = shift_lvl;
        raw_in[IDX_LOAD]  = load_lvl;
    end

    shreg_sync #(
        .N      (NUM_SAMPLED),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (smp)
    );

    shreg_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_s (smp[IDX_SHIFT]),
        .load_s  (smp[IDX_LOAD]),
        .pulse   (pulse)
    );

    assign shift_pulse = pulse.shift;
    assign load_pulse  = pulse.load;
    assign chain_rst_n = clr_n & rst_n;

    shreg_chain #(
        .WIDTH (WIDTH)
    ) u_chain (
        .clk         (clk),
        .clr_async_n (chain_rst_n),
        .step        (shift_pulse),
        .din         (smp[IDX_DATA]),
        .stages      (stages)
    );

    shreg_hold #(
        .WIDTH (WIDTH)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (load_pulse),
        .src     (stages),
        .held    (held)
    );

    always_comb begin
        par_oe  = {WIDTH{~oe_n}};
        par_q   = held & par_oe;
        ser_out = stages[TOP];
    end

endmodule

// File: rtl/shreg_latch_chk.sv
module shreg_latch_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             oe_n,
    input logic             shift_pulse,
    input logic             load_pulse,
    input logic [WIDTH-1:0] stages,
    input logic [WIDTH-1:0] held,
    input logic [WIDTH-1:0] par_q,
    input logic [WIDTH-1:0] par_oe,
    input logic             ser_out
);

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && clr_n) |=> (!clr_n || stages[WIDTH-1:1] == $past(stages[WIDTH-2:0]))); // R1

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (held == $past(stages))); // R2

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (ser_out == 1'b0 && stages == '0)); // R3

    AST_CLEAR_SPARES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !load_pulse) |=> $stable(held)); // R3

    AST_RELEASED_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (par_oe == '0 && par_q == '0)); // R4

    AST_DRIVEN_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (par_oe == '1 && par_q == held)); // R4

    AST_CHAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_pulse && clr_n) |=> (!clr_n || $stable(stages))); // R6

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(held)); // R6

endmodule

bind shreg_latch shreg_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_n       (clr_n),
    .oe_n        (oe_n),
    .shift_pulse (shift_pulse),
    .load_pulse  (load_pulse),
    .stages      (stages),
    .held        (held),
    .par_q       (par_q),
    .par_oe      (par_oe),
    .ser_out     (ser_out)
);

// File: tb/shreg_latch_tb.sv
`timescale 1ns/1ps
module shreg_latch_tb;

    localparam int W = 8;
    localparam int HOLD_CYC = 4;

    logic clk = 1'b0;
    logic rst_n, din, sh, lt, clr_n, oe_n;
    logic [W-1:0] p1, e1, p2, e2;
    logic s1, s2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [W-1:0] sr1, sr2, h1, h2;
    logic oe_ref;

    always #4 clk = ~clk;

    shreg_latch #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(din), .shift_lvl(sh), .load_lvl(lt),
        .clr_n(clr_n), .oe_n(oe_n), .par_q(p1), .par_oe(e1), .ser_out(s1)
    );

    shreg_latch #(.WIDTH(W)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .ser_in(s1), .shift_lvl(sh), .load_lvl(lt),
        .clr_n(clr_n), .oe_n(oe_n), .par_q(p2), .par_oe(e2), .ser_out(s2)
    );

    function automatic logic [W-1:0] shifted(input logic [W-1:0] v, input logic b);
        return {v[W-2:0], b};
    endfunction

    function automatic logic [W-1:0] exp_par(input logic [W-1:0] h, input logic off);
        return off ? '0 : h;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " par_oe first"},  e1, oe_ref ? '0 : '1);
        chk({req, " par_q first"},   p1, exp_par(h1, oe_ref));
        chk({req, " ser_out first"}, {{(W-1){1'b0}}, s1}, {{(W-1){1'b0}}, sr1[W-1]});
        chk({req, " par_q second"},  p2, exp_par(h2, oe_ref));
        chk({req, " ser_out second"},{{(W-1){1'b0}}, s2}, {{(W-1){1'b0}}, sr2[W-1]});
    endtask

    // raise the chosen strobes, hold them, drop them, update the model
    task automatic step(input logic s, input logic l, input logic b, input int hi_cyc, input string req);
        @(negedge clk);
        sh = s; lt = l; din = b;
        repeat (hi_cyc) @(negedge clk);
        sh = 1'b0; lt = 1'b0;
        repeat (HOLD_CYC) @(negedge clk);
        if (l) begin h1 = sr1; h2 = sr2; end         // R7: pre-shift contents
        if (s) begin sr2 = shifted(sr2, sr1[W-1]); sr1 = shifted(sr1, b); end
        check_all(req);
    endtask

    task automatic clear_pulse(input string req);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        sr1 = '0; sr2 = '0;
        chk({req, " ser_out cleared at once"}, {{(W-1){1'b0}}, s1 | s2}, '0);
        repeat (2) @(negedge clk);
        check_all(req);
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all(req);
    endtask

    task automatic set_oe(input logic v, input string req);
        @(negedge clk);
        oe_n = v; oe_ref = v;
        #1;
        check_all(req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] pat;
        logic [W-1:0] old_h;
        int unsigned r;
        rst_n = 1'b0; clr_n = 1'b0; sh = 1'b0; lt = 1'b0; din = 1'b0; oe_n = 1'b0;
        sr1 = '0; sr2 = '0; h1 = '0; h2 = '0; oe_ref = 1'b0;
        r = $urandom(32'd7091);
        repeat (5) @(negedge clk);
        rst_n = 1'b1; clr_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R8 after reset");

        // R10 / R1 / R2: 16 shifts through the chain, then one load
        pat = 16'hC3A5;
        for (int i = 2*W-1; i >= 0; i--) step(1'b1, 1'b0, pat[i], HOLD_CYC, "R1 shift");
        step(1'b0, 1'b1, 1'b0, HOLD_CYC, "R2 load");
        chk("R10 second word", p2, pat[2*W-1:W]);
        chk("R10 first word",  p1, pat[W-1:0]);

        // R9: load takes effect after exactly SYNC+1 clock edges
        step(1'b1, 1'b0, ~sr1[W-1], HOLD_CYC, "R1 shift before latency");
        old_h = h1;
        @(negedge clk); lt = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 not yet loaded after two edges", p1, old_h);
        @(negedge clk);
        chk("R9 loaded after three edges", p1, sr1);
        lt = 1'b0;
        h1 = sr1; h2 = sr2;
        repeat (HOLD_CYC) @(negedge clk);
        check_all("R9 settle");

        // R7: both strobes together
        step(1'b1, 1'b1, 1'b1, HOLD_CYC, "R7 simultaneous");
        step(1'b1, 1'b1, 1'b0, HOLD_CYC, "R7 simultaneous");

        // R6: shift level held high for a long time gives one shift only
        step(1'b1, 1'b0, 1'b1, 40, "R6 long high shift");
        step(1'b0, 1'b0, 1'b0, HOLD_CYC, "R6 idle");

        // R3: clear with a non-zero holding register
        step(1'b0, 1'b1, 1'b0, HOLD_CYC, "R3 prep load");
        clear_pulse("R3 clear");
        step(1'b0, 1'b1, 1'b0, HOLD_CYC, "R3 load after clear");

        // R4 / R5: outputs released, serial still live, load while released
        step(1'b1, 1'b0, 1'b1, HOLD_CYC, "R5 prep");
        set_oe(1'b1, "R4 released");
        step(1'b1, 1'b1, 1'b1, HOLD_CYC, "R5 shift while released");
        set_oe(1'b0, "R4 driven again");

        // random mix
        for (int n = 0; n < 300; n++) begin
            r = $urandom % 8;
            case (r)
                0, 1, 2, 3: step(1'b1, 1'b0, 1'($urandom), HOLD_CYC, "R1 random shift");
                4:          step(1'b0, 1'b1, 1'b0, HOLD_CYC, "R2 random load");
                5:          step(1'b1, 1'b1, 1'($urandom), HOLD_CYC, "R7 random both");
                6:          set_oe(~oe_ref, "R4 random enable");
                default:    clear_pulse("R3 random clear");
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule